// File: doc/BRIEF.md
# UART Register Front End with Receive Queue

This block is the register-level face of a UART. A host reaches it through a word-addressed bus with a 12-bit byte offset and separate read and write strobes. Received characters arrive on a byte-wide stream with a valid/ready handshake and wait in a 16-deep circular queue until the host reads the data register. A write to the data register sends its low byte out on a transmit stream for one cycle. Serial bit timing, baud generation, DMA, break, loopback and modem lines are handled elsewhere. The block only holds their configuration values where it has registers for them.

Status comes from a flag register and from a pair of interrupt sources, transmit and receive. Each source has a raw bit and a mask bit. A single interrupt line is the OR of the raw bits that are enabled. The receive source fires when the queue fill reaches a programmable threshold and drops when reads bring the fill back below it.

A line-control bit selects the queue depth. With the bit set the full 16 entries are used. With it clear the queue acts as a single holding register. Eight identification bytes are mapped at the top of the address space.

Top module: `uart_csr_front`

Register word index is offset bits [11:2]: 0 data, 6 flags, 8 low-power divisor (8 bits), 9 integer baud divisor (16 bits), 10 fractional baud divisor (6 bits), 11 line control (8 bits), 12 control (16 bits, reset 0x0300), 13 level select (6 bits, reset 0x12), 14 mask (11 bits), 15 raw status, 16 masked status, 17 clear, 18 DMA control (3 bits). Interrupt bit 5 is transmit and bit 4 is receive. Flag bits are 7 transmit empty, 6 receive full, 5 transmit full and 4 receive empty.

## Requirements
- R1: After reset the flag register reads 0x90, the mask and raw status read 0, rx_ready is 1, tx_valid is 0 and irq is 0.
- R2: A write to the data register drives tx_data with bits [7:0] of the written word and tx_valid high for exactly the next cycle. The same write sets raw status bit 5.
- R3: irq is high exactly when raw status AND mask is nonzero. A read of masked status returns raw status AND mask.
- R4: A write to the clear register clears every raw status bit that is 1 in the written value and leaves the other bits unchanged.
- R5: Each data-register read returns the oldest stored byte and removes it, so bytes come out in arrival order. The circular pointers wrap after 16 entries. A read of an empty queue removes nothing.
- R6: With line-control bit 4 set, rx_ready is high while fewer than 16 bytes are stored. Flag bit 6 sets when the 16th byte is stored and clears on any data-register read.
- R7: With line-control bit 4 clear, rx_ready is high only when the queue is empty, and flag bit 6 sets as soon as one byte is stored.
- R8: Flag bit 4 is 1 exactly when the queue holds no bytes.
- R9: The receive threshold is ((level select >> 1) & 0x1C) with line-control bit 4 set, and 1 with it clear. It is recomputed when line control or level select is written. Raw bit 4 sets when an accepted byte makes the fill equal to the threshold. It clears when a read makes the fill equal to the threshold minus one.
- R10: Reads at offsets 0xFE0 to 0xFFC return 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, one byte per word, in that order.
- R11: Writes to the flag register, to the status registers or to unmapped offsets change no state. Reads of unmapped offsets return 0.
- R12: The divisor, line-control, control, level-select, mask and DMA-control registers read back the written value truncated to their widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; data-register reads pop the queue |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Block can accept a byte this cycle |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | One-cycle strobe for tx_data |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that rx_valid is only counted as accepted when rx_ready is high. They also assume that a bus read and a bus write never land in the same cycle. The stimulus holds each strobe for one cycle at a time and never overlaps them. Receive bytes are offered one per access, and a byte is scored as stored only if the bench sees rx_ready high before the clock edge. Pushes and data reads are never issued in the same cycle, so the threshold comparisons see the fill change by exactly one.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

    // Register word indices (byte offset >> 2)
    localparam logic [9:0] IDX_DATA   = 10'd0;
    localparam logic [9:0] IDX_FLAG   = 10'd6;
    localparam logic [9:0] IDX_LPDIV  = 10'd8;
    localparam logic [9:0] IDX_IBAUD  = 10'd9;
    localparam logic [9:0] IDX_FBAUD  = 10'd10;
    localparam logic [9:0] IDX_LINE   = 10'd11;
    localparam logic [9:0] IDX_CTRL   = 10'd12;
    localparam logic [9:0] IDX_LEVEL  = 10'd13;
    localparam logic [9:0] IDX_MASK   = 10'd14;
    localparam logic [9:0] IDX_RAW    = 10'd15;
    localparam logic [9:0] IDX_MSKST  = 10'd16;
    localparam logic [9:0] IDX_CLEAR  = 10'd17;
    localparam logic [9:0] IDX_DMA    = 10'd18;

    localparam int IRQ_W      = 11;
    localparam int IRQ_TX_BIT = 5;
    localparam int IRQ_RX_BIT = 4;
    localparam int LINE_QEN_BIT = 4;

    typedef struct packed {
        logic [7:0]       lpdiv;
        logic [15:0]      ibaud;
        logic [5:0]       fbaud;
        logic [7:0]       line;
        logic [15:0]      ctrl;
        logic [5:0]       level;
        logic [2:0]       dma;
        logic [IRQ_W-1:0] mask;
        logic [IRQ_W-1:0] raw;
        logic [4:0]       thresh;
        logic             rx_full;
        logic [7:0]       tx_byte;
        logic             tx_valid;
    } csr_state_t;

    function automatic logic [4:0] calc_thresh(input logic [7:0] line, input logic [5:0] level);
        return line[LINE_QEN_BIT] ? {level[5:3], 2'b00} : 5'd1;
    endfunction

endpackage

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
    parameter int DEPTH = 16,          // power of two
    parameter int WIDTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] fill;
    } q_state_t;

    q_state_t q_q, q_d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic pop_ok;

    assign pop_ok    = pop && (q_q.fill != '0);
    assign head_data = mem[q_q.rd_ptr];
    assign count     = q_q.fill;

    always_comb begin
        q_d = q_q;
        if (push)   q_d.wr_ptr = q_q.wr_ptr + 1'b1;
        if (pop_ok) q_d.rd_ptr = q_q.rd_ptr + 1'b1;
        q_d.fill = q_q.fill + CNT_W'(push) - CNT_W'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[q_q.wr_ptr] <= push_data;
    end

    // R5: the queue is never written past its depth
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && !pop && q_q.fill == CNT_W'(DEPTH)));

    // R5: a read of an empty queue leaves it empty
    a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && q_q.fill == '0) |=> (q_q.fill == '0));

endmodule

// File: rtl/uart_id_rom.sv
module uart_id_rom (
    input  logic [2:0] idx,
    output logic [7:0] id_byte
);
    always_comb begin
        unique case (idx)
            3'd0: id_byte = 8'h11;
            3'd1: id_byte = 8'h10;
            3'd2: id_byte = 8'h14;
            3'd3: id_byte = 8'h00;
            3'd4: id_byte = 8'h0D;
            3'd5: id_byte = 8'hF0;
            3'd6: id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    end
endmodule

// File: rtl/uart_csr_front.sv
module uart_csr_front
    import uart_csr_pkg::*;
#(
    parameter int RX_DEPTH = 16,
    parameter int ID_BASE  = 32'hFE0,
    localparam int CNT_W   = $clog2(RX_DEPTH + 1),
    localparam int ID_SPAN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    input  logic [7:0]  rx_data,
    input  logic        rx_valid,
    output logic        rx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        irq
);

    csr_state_t q, d;

    logic [9:0]       sel;
    logic             id_hit;
    logic [2:0]       id_idx;
    logic [7:0]       id_byte;
    logic             queue_en;
    logic [CNT_W-1:0] fill;
    logic [7:0]       head;
    logic             push, pop, pop_ok;
    logic [CNT_W-1:0] fill_after_pop, fill_final;
    logic             rx_set, rx_clr;
    logic             wr_reg, rd_data;
    logic [31:0]      flags;
    logic             unused_bits;

    assign unused_bits = ^{bus_wdata[31:16], bus_addr[1:0]};

    assign sel    = bus_addr[11:2];
    assign id_hit = (32'(bus_addr) >= ID_BASE) && (32'(bus_addr) < ID_BASE + ID_SPAN);
    assign id_idx = 3'((32'(bus_addr) - ID_BASE) >> 2);

    assign queue_en = q.line[LINE_QEN_BIT];
    assign rx_ready = queue_en ? (fill < CNT_W'(RX_DEPTH)) : (fill == '0);
    assign push     = rx_valid && rx_ready;
    assign wr_reg   = bus_wr && !id_hit;
    assign rd_data  = bus_rd && !id_hit && (sel == IDX_DATA);
    assign pop      = rd_data;
    assign pop_ok   = pop && (fill != '0);

    assign fill_after_pop = fill - CNT_W'(pop_ok);
    assign fill_final     = fill_after_pop + CNT_W'(push);
    assign rx_clr = pop_ok && (32'(fill_after_pop) + 1 == 32'(q.thresh));
    assign rx_set = push && (32'(fill_final) == 32'(q.thresh));

    uart_rx_queue #(.DEPTH(RX_DEPTH), .WIDTH(8)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (rx_data),
        .pop       (pop),
        .head_data (head),
        .count     (fill)
    );

    uart_id_rom u_id (
        .idx     (id_idx),
        .id_byte (id_byte)
    );

    // Next-state computation
    always_comb begin
        d = q;
        d.tx_valid = 1'b0;
        if (wr_reg) begin
            case (sel)
                IDX_DATA: begin
                    d.tx_byte = bus_wdata[7:0];
                    d.tx_valid = 1'b1;
                    d.raw[IRQ_TX_BIT] = 1'b1;
                end
                IDX_LPDIV: d.lpdiv = bus_wdata[7:0];
                IDX_IBAUD: d.ibaud = bus_wdata[15:0];
                IDX_FBAUD: d.fbaud = bus_wdata[5:0];
                IDX_LINE: begin
                    d.line   = bus_wdata[7:0];
                    d.thresh = calc_thresh(bus_wdata[7:0], q.level);
                end
                IDX_CTRL:  d.ctrl = bus_wdata[15:0];
                IDX_LEVEL: begin
                    d.level  = bus_wdata[5:0];
                    d.thresh = calc_thresh(q.line, bus_wdata[5:0]);
                end
                IDX_MASK:  d.mask = bus_wdata[IRQ_W-1:0];
                IDX_CLEAR: d.raw  = q.raw & ~bus_wdata[IRQ_W-1:0];
                IDX_DMA:   d.dma  = bus_wdata[2:0];
                default: ;
            endcase
        end
        // receive source: hardware set wins over a same-cycle clear
        if (rx_clr) d.raw[IRQ_RX_BIT] = 1'b0;
        if (rx_set) d.raw[IRQ_RX_BIT] = 1'b1;
        if (rd_data) d.rx_full = 1'b0;
        if (push && (!queue_en || fill_final == CNT_W'(RX_DEPTH))) d.rx_full = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.ctrl   <= 16'h0300;
            q.level  <= 6'h12;
            q.thresh <= 5'd1;
        end else begin
            q <= d;
        end
    end

    assign flags = {24'd0, 1'b1, q.rx_full, 1'b0, (fill == '0), 4'd0};

    // Read data mux
    always_comb begin
        bus_rdata = '0;
        if (id_hit) begin
            bus_rdata = {24'd0, id_byte};
        end else begin
            case (sel)
                IDX_DATA:  bus_rdata = {24'd0, head};
                IDX_FLAG:  bus_rdata = flags;
                IDX_LPDIV: bus_rdata = {24'd0, q.lpdiv};
                IDX_IBAUD: bus_rdata = {16'd0, q.ibaud};
                IDX_FBAUD: bus_rdata = {26'd0, q.fbaud};
                IDX_LINE:  bus_rdata = {24'd0, q.line};
                IDX_CTRL:  bus_rdata = {16'd0, q.ctrl};
                IDX_LEVEL: bus_rdata = {26'd0, q.level};
                IDX_MASK:  bus_rdata = {21'd0, q.mask};
                IDX_RAW:   bus_rdata = {21'd0, q.raw};
                IDX_MSKST: bus_rdata = {21'd0, q.raw & q.mask};
                IDX_DMA:   bus_rdata = {29'd0, q.dma};
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign tx_data  = q.tx_byte;
    assign tx_valid = q.tx_valid;
    assign irq      = |(q.raw & q.mask);

    // R2: a data write produces the transmit strobe and raises the transmit source
    a_r2_tx_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !id_hit && sel == IDX_DATA) |=> (tx_valid && q.raw[IRQ_TX_BIT]));

    // R3: no interrupt without an enabled source
    a_r3_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (q.mask != '0));

    // R6: a full queue refuses input
    a_r6_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == CNT_W'(RX_DEPTH)) |-> !rx_ready);

    // R7: single-entry mode reports full once a byte is taken
    a_r7_single_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !queue_en) |=> q.rx_full);

    // R8: an empty queue always accepts
    a_r8_empty_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0) |-> rx_ready);

endmodule

// File: tb/uart_csr_front_bench.sv
`timescale 1ns/1ps
module uart_csr_front_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] rx_exp[$];
    logic [7:0] tx_exp[$];

    always #2.5 clk = ~clk;

    uart_csr_front u_uart_csr_front (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .irq(irq)
    );

    localparam logic [11:0] A_DATA = 12'h000, A_FLAG = 12'h018, A_LPDIV = 12'h020,
        A_IBAUD = 12'h024, A_FBAUD = 12'h028, A_LINE = 12'h02C, A_CTRL = 12'h030,
        A_LEVEL = 12'h034, A_MASK = 12'h038, A_RAW = 12'h03C, A_MSKST = 12'h040,
        A_CLEAR = 12'h044, A_DMA = 12'h048;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    // Scoreboard driver: offer a byte, record it if accepted
    task automatic push_rx(input string req, input logic [7:0] b, input logic exp_ready);
        @(negedge clk);
        rx_data = b; rx_valid = 1'b1;
        #1 check(req, {31'd0, rx_ready}, {31'd0, exp_ready});
        if (rx_ready) rx_exp.push_back(b);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // Scoreboard monitor for received bytes: R5 ordering
    task automatic pop_rx();
        logic [31:0] v;
        logic [7:0] e;
        rd(A_DATA, v);
        if (rx_exp.size() == 0) begin
            checks++; errors++;
            $display("FAIL R5: got %h expected <none>", v);
        end else begin
            e = rx_exp.pop_front();
            check("R5 order", v, {24'd0, e});
        end
    endtask

    task automatic send_tx(input logic [31:0] v);
        tx_exp.push_back(v[7:0]);
        wr(A_DATA, v);
    endtask

    // Transmit monitor: R2
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (tx_exp.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2: got %h expected <no strobe>", tx_data);
            end else begin
                check("R2 tx byte", {24'd0, tx_data}, {24'd0, tx_exp.pop_front()});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rx_ready", {31'd0, rx_ready}, 32'd1);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
        rd_chk("R1 flags", A_FLAG, 32'h90);
        rd_chk("R1 mask", A_MASK, 32'h0);
        rd_chk("R1 raw", A_RAW, 32'h0);

        // R12 readback with truncation
        wr(A_IBAUD, 32'hABCD1234); rd_chk("R12 ibaud", A_IBAUD, 32'h1234);
        wr(A_FBAUD, 32'hFF);       rd_chk("R12 fbaud", A_FBAUD, 32'h3F);
        wr(A_LPDIV, 32'h1A5);      rd_chk("R12 lpdiv", A_LPDIV, 32'hA5);
        rd_chk("R12 ctrl reset", A_CTRL, 32'h0300);
        wr(A_CTRL, 32'h12345);     rd_chk("R12 ctrl", A_CTRL, 32'h2345);
        wr(A_DMA, 32'hF);          rd_chk("R12 dma", A_DMA, 32'h7);
        rd_chk("R12 level reset", A_LEVEL, 32'h12);

        // R11 ignored writes and unmapped reads
        wr(A_FLAG, 32'hFF);        rd_chk("R11 flags", A_FLAG, 32'h90);
        wr(12'h004, 32'hFFFF);     rd_chk("R11 unmapped", 12'h004, 32'h0);
        wr(A_RAW, 32'h30);         rd_chk("R11 raw write", A_RAW, 32'h0);
        wr(A_MSKST, 32'h30);       rd_chk("R11 mskst write", A_RAW, 32'h0);
        rd_chk("R11 ibaud kept", A_IBAUD, 32'h1234);
        rd_chk("R11 high unmapped", 12'h100, 32'h0);

        // R10 identification bytes
        for (int i = 0; i < 8; i++) begin
            logic [7:0] idv [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
            rd_chk("R10 id", 12'hFE0 + 12'(i * 4), {24'd0, idv[i]});
        end

        // R2 transmit, R3 mask, R4 clear
        send_tx(32'h41);
        send_tx(32'h1C3);
        rd_chk("R2 raw tx", A_RAW, 32'h20);
        check("R3 irq masked off", {31'd0, irq}, 32'd0);
        wr(A_MASK, 32'h20);
        check("R3 irq on", {31'd0, irq}, 32'd1);
        rd_chk("R3 mskst", A_MSKST, 32'h20);
        wr(A_CLEAR, 32'h10);
        rd_chk("R4 other bit kept", A_RAW, 32'h20);
        wr(A_CLEAR, 32'h20);
        rd_chk("R4 cleared", A_RAW, 32'h0);
        check("R3 irq off", {31'd0, irq}, 32'd0);
        wr(A_MASK, 32'h0);

        // R7 single-entry mode, threshold 1 (R9)
        push_rx("R7 first accepted", 8'h5A, 1'b1);
        rd_chk("R7 full flag", A_FLAG, 32'hC0);
        rd_chk("R9 rx source set", A_RAW, 32'h10);
        push_rx("R7 second refused", 8'h66, 1'b0);
        pop_rx();
        rd_chk("R8 empty again", A_FLAG, 32'h90);
        rd_chk("R9 rx source cleared", A_RAW, 32'h0);
        rd(A_DATA, v);
        rd_chk("R5 empty read no pop", A_FLAG, 32'h90);

        // R6 queue mode, threshold (0x12>>1)&0x1C = 8
        wr(A_LINE, 32'h10);
        for (int i = 0; i < 7; i++) push_rx("R6 accept", 8'(8'h80 + i), 1'b1);
        rd_chk("R9 below threshold", A_RAW, 32'h0);
        rd_chk("R8 not empty", A_FLAG, 32'h80);
        push_rx("R6 accept", 8'h87, 1'b1);
        rd_chk("R9 threshold reached", A_RAW, 32'h10);
        for (int i = 8; i < 16; i++) push_rx("R6 accept", 8'(8'h80 + i), 1'b1);
        rd_chk("R6 full flag", A_FLAG, 32'hC0);
        push_rx("R6 17th refused", 8'hEE, 1'b0);
        for (int i = 0; i < 8; i++) pop_rx();
        rd_chk("R6 full cleared", A_FLAG, 32'h80);
        rd_chk("R9 held above threshold-1", A_RAW, 32'h10);
        pop_rx();
        rd_chk("R9 cleared at threshold-1", A_RAW, 32'h0);
        for (int i = 0; i < 7; i++) pop_rx();
        rd_chk("R8 drained", A_FLAG, 32'h90);

        // R9 other level: (0x08>>1)&0x1C = 4
        wr(A_LEVEL, 32'h08);
        for (int i = 0; i < 3; i++) push_rx("R9 accept", 8'(8'h30 + i), 1'b1);
        rd_chk("R9 level4 below", A_RAW, 32'h0);
        push_rx("R9 accept", 8'h33, 1'b1);
        rd_chk("R9 level4 set", A_RAW, 32'h10);
        pop_rx();
        rd_chk("R9 level4 cleared", A_RAW, 32'h0);
        for (int i = 0; i < 3; i++) pop_rx();

        // R9 line write recomputes threshold to 1; R3 on receive source
        wr(A_LINE, 32'h00);
        wr(A_MASK, 32'h10);
        push_rx("R7 accept", 8'hC4, 1'b1);
        check("R3 irq rx", {31'd0, irq}, 32'd1);
        rd_chk("R3 mskst rx", A_MSKST, 32'h10);
        pop_rx();
        check("R3 irq rx off", {31'd0, irq}, 32'd0);

        repeat (3) @(negedge clk);
        check("R2 all tx seen", tx_exp.size(), 32'd0);
        check("R5 all rx seen", rx_exp.size(), 32'd0);
        summary();
        $finish;
    end

endmodule